// File: doc/BRIEF.md
# Wired-AND Shared Bus Resolver

This block stands in for an on-chip shared bus that would otherwise be built from three-state drivers. Each of several drivers offers a data word and an enable. The block merges them into one bus word with pure logic. The result is the same as a bus with pull-ups where any active driver can pull a bit low. No driver enabled leaves every bit high. One driver enabled passes its word through unchanged. Several drivers enabled give a bitwise AND of their words.

Alongside the data, the block reports how many drivers are active. It raises a flag when none are enabled and another when two or more collide. When exactly one driver is enabled, it gives that driver's number with a valid bit. A separate active-low request line is merged by the same rule: any source pulling low asserts it, and it rests high otherwise.

A parameter selects the output form. The outputs can be purely combinational, or they can be captured in one register stage. That stage has an asynchronous active-low reset whose release is synchronised to the clock.

Top module: `wired_bus_resolver`

## Requirements
- R1: With no bit of `drv_en` set, every bit of `bus_out` is 1.
- R2: With exactly one bit k of `drv_en` set, `bus_out` equals driver k's slot `drv_data[k*WIDTH +: WIDTH]` (driver 0 in the least significant slot).
- R3: With two or more enables set, each bit of `bus_out` is 0 when any enabled driver holds 0 there and 1 otherwise; disabled drivers' data has no effect.
- R4: `multi_drive` is 1 exactly when two or more bits of `drv_en` are set.
- R5: `no_drive` is 1 exactly when no bit of `drv_en` is set.
- R6: `sole_valid` is 1 exactly when one bit of `drv_en` is set, and then `sole_idx` holds that bit's position; otherwise `sole_idx` carries no meaning.
- R7: `irq_n` is 0 when any bit of `irq_pull` is 1 and 1 when none is.
- R8: With `OUT_MODE` = OUT_REG, every output shows the resolution of the inputs present at the previous rising clock edge. With OUT_COMB, every output follows its inputs in the same cycle.
- R9: In OUT_REG mode, while `rst_n` is low the outputs hold `bus_out` all ones, `no_drive` 1, `multi_drive` 0, `sole_valid` 0, `sole_idx` 0 and `irq_n` 1, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | NUM_DRIVERS | Per-driver enable, bit i for driver i |
| drv_data | input | NUM_DRIVERS*WIDTH | Packed driver words, driver 0 lowest |
| irq_pull | input | NUM_IRQ | Per-source pull-low request |
| bus_out | output | WIDTH | Resolved bus word |
| multi_drive | output | 1 | Two or more drivers enabled |
| no_drive | output | 1 | No driver enabled |
| sole_idx | output | $clog2(NUM_DRIVERS) | Number of the single enabled driver |
| sole_valid | output | 1 | Exactly one driver enabled |
| irq_n | output | 1 | Merged active-low request line |

## Verification
A broken lane term or a swapped slot shows up as a wrong `bus_out` bit. It appears in the same cycle in combinational mode, or one edge later when registered. A wrong enable count shows up together with it as disagreeing `no_drive`, `multi_drive` or `sole_valid` flags. Both output forms are compared at once against a reference that applies the AND rule. Each stimulus therefore exposes a fault within a single cycle. The reset values are checked while the inputs are busy, so a leak from the inputs into the register during reset cannot hide.

// File: rtl/wbus_pkg.sv
package wbus_pkg;

  // Output form of the resolver
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

endpackage

// File: rtl/wand_lane_resolver.sv
// Per-bit pull-up / wired-AND merge of several sources.
module wand_lane_resolver #(
  parameter int NUM_SRC = 4,
  parameter int LANE_W  = 8
) (
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC*LANE_W-1:0] src_data,
  output logic [LANE_W-1:0]         merged
);

  for (genvar b = 0; b < LANE_W; b++) begin : g_lane
    logic [NUM_SRC-1:0] pass_term;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      // A released source leaves the bit to the pull-up.
      assign pass_term[s] = src_data[s*LANE_W + b] | ~src_en[s];
    end
    assign merged[b] = &pass_term;
  end

endmodule

// File: rtl/drive_census.sv
// Counts active enables and extracts the index of a lone driver.
module drive_census #(
  parameter int NUM_SRC = 4,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int CNT_W  = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] src_en,
  output logic               multi,
  output logic               none,
  output logic [IDX_W-1:0]   lone_idx,
  output logic               lone
);

  logic [CNT_W-1:0] active_cnt;
  logic [IDX_W-1:0] idx_acc;

  always_comb begin
    active_cnt = '0;
    idx_acc    = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_en[i]) begin
        active_cnt = active_cnt + CNT_W'(1);
        idx_acc    = idx_acc | IDX_W'(i);
      end
    end
  end

  assign none     = (active_cnt == '0);
  assign lone     = (active_cnt == CNT_W'(1));
  assign multi    = (active_cnt > CNT_W'(1));
  assign lone_idx = lone ? idx_acc : '0;

endmodule

// File: rtl/resolve_out_stage.sv
// Optional output register with asynchronous assert, synchronous release reset.
module resolve_out_stage
  import wbus_pkg::*;
#(
  parameter int                PW      = 8,
  parameter out_mode_e         MODE    = OUT_REG,
  parameter logic [PW-1:0]     RST_VAL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] d,
  output logic [PW-1:0] q
);

  if (MODE == OUT_REG) begin : g_reg
    logic       rst_meta, rst_sync_n;
    logic [PW-1:0] q_r, q_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rst_meta   <= 1'b0;
        rst_sync_n <= 1'b0;
      end else begin
        rst_meta   <= 1'b1;
        rst_sync_n <= rst_meta;
      end
    end

    always_comb q_nxt = d;

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) q_r <= RST_VAL;
      else             q_r <= q_nxt;
    end

    assign q = q_r;

    // R8: registered output tracks the prior cycle's input
    a_r8_one_cycle_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(rst_sync_n) || (q == $past(d)) || !$past(rst_sync_n));

    // R9: outputs sit at the reset word while reset is applied
    a_r9_reset_word: assert property (@(posedge clk)
      !rst_sync_n |=> (!rst_sync_n || $past(q) == RST_VAL) );
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst_n;
    assign q = d;
  end

endmodule

// File: rtl/wired_bus_resolver.sv
module wired_bus_resolver
  import wbus_pkg::*;
#(
  parameter int        NUM_DRIVERS = 4,
  parameter int        WIDTH       = 8,
  parameter int        NUM_IRQ     = 3,
  parameter out_mode_e OUT_MODE    = OUT_REG,
  localparam int       IDX_W       = $clog2(NUM_DRIVERS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_DRIVERS-1:0]       drv_en,
  input  logic [NUM_DRIVERS*WIDTH-1:0] drv_data,
  input  logic [NUM_IRQ-1:0]           irq_pull,
  output logic [WIDTH-1:0]             bus_out,
  output logic                         multi_drive,
  output logic                         no_drive,
  output logic [IDX_W-1:0]             sole_idx,
  output logic                         sole_valid,
  output logic                         irq_n
);

  localparam int PW = WIDTH + IDX_W + 4;
  localparam logic [PW-1:0] RST_WORD =
    {{WIDTH{1'b1}}, 1'b0, 1'b1, {IDX_W{1'b0}}, 1'b0, 1'b1};

  logic [WIDTH-1:0] bus_c;
  logic             multi_c, none_c, sole_c, irq_c;
  logic [IDX_W-1:0] idx_c;
  logic [NUM_IRQ-1:0] irq_low_level;
  logic [PW-1:0]    pack_d, pack_q;

  wand_lane_resolver #(.NUM_SRC(NUM_DRIVERS), .LANE_W(WIDTH)) u_data_lanes (
    .src_en  (drv_en),
    .src_data(drv_data),
    .merged  (bus_c)
  );

  drive_census #(.NUM_SRC(NUM_DRIVERS)) u_census (
    .src_en  (drv_en),
    .multi   (multi_c),
    .none    (none_c),
    .lone_idx(idx_c),
    .lone    (sole_c)
  );

  // Request sources only ever drive a low level when enabled.
  assign irq_low_level = '0;

  wand_lane_resolver #(.NUM_SRC(NUM_IRQ), .LANE_W(1)) u_irq_line (
    .src_en  (irq_pull),
    .src_data(irq_low_level),
    .merged  (irq_c)
  );

  assign pack_d = {bus_c, multi_c, none_c, idx_c, sole_c, irq_c};

  resolve_out_stage #(.PW(PW), .MODE(OUT_MODE), .RST_VAL(RST_WORD)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pack_d),
    .q    (pack_q)
  );

  assign {bus_out, multi_drive, no_drive, sole_idx, sole_valid, irq_n} = pack_q;

  // R1: idle bus floats to all ones
  a_r1_idle_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en == '0) |-> (bus_c == '1));

  // R2: lone driver passes its slot through
  a_r2_lone_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    sole_c |-> (bus_c == drv_data[idx_c*WIDTH +: WIDTH]));

  // R3: any enabled driver holding a zero pulls the bit low
  for (genvar d = 0; d < NUM_DRIVERS; d++) begin : g_chk
    a_r3_no_bit_above_driver: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en[d] |-> ((bus_c & ~drv_data[d*WIDTH +: WIDTH]) == '0));
  end

  // R4/R5: census flags agree with a population count
  a_r4_contention_flag: assert property (@(posedge clk) disable iff (!rst_n)
    multi_c == ($countones(drv_en) > 1));
  a_r5_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
    none_c == (drv_en == '0));

  // R6: reported index points at an enabled driver
  a_r6_index_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    sole_c |-> drv_en[idx_c]);

  // R7: request line low while any source pulls
  a_r7_request_line: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pull != '0) |-> !irq_c);

endmodule

// File: tb/tb_wired_bus_resolver.sv
module tb_wired_bus_resolver;
  import wbus_pkg::*;

  localparam int N  = 4;
  localparam int W  = 8;
  localparam int NI = 3;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]   drv_en;
  logic [N*W-1:0] drv_data;
  logic [NI-1:0]  irq_pull;

  logic [W-1:0]  r_bus, c_bus;
  logic          r_multi, c_multi, r_none, c_none, r_valid, c_valid, r_irq, c_irq;
  logic [IW-1:0] r_idx, c_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wired_bus_resolver #(.NUM_DRIVERS(N), .WIDTH(W), .NUM_IRQ(NI), .OUT_MODE(OUT_REG)) dut (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .drv_data(drv_data), .irq_pull(irq_pull),
    .bus_out(r_bus), .multi_drive(r_multi), .no_drive(r_none), .sole_idx(r_idx),
    .sole_valid(r_valid), .irq_n(r_irq));

  wired_bus_resolver #(.NUM_DRIVERS(N), .WIDTH(W), .NUM_IRQ(NI), .OUT_MODE(OUT_COMB)) dut_c (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .drv_data(drv_data), .irq_pull(irq_pull),
    .bus_out(c_bus), .multi_drive(c_multi), .no_drive(c_none), .sole_idx(c_idx),
    .sole_valid(c_valid), .irq_n(c_irq));

  function automatic logic [W-1:0] ref_bus(input logic [N-1:0] en, input logic [N*W-1:0] dat);
    logic [W-1:0] acc = '1;
    for (int i = 0; i < N; i++) if (en[i]) acc = acc & dat[i*W +: W];
    return acc;
  endfunction

  function automatic int ref_count(input logic [N-1:0] en);
    int c = 0;
    for (int i = 0; i < N; i++) if (en[i]) c++;
    return c;
  endfunction

  function automatic int ref_first(input logic [N-1:0] en);
    for (int i = 0; i < N; i++) if (en[i]) return i;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_set(input bit regd, input logic [N-1:0] en, input logic [N*W-1:0] dat,
                           input logic [NI-1:0] pull);
    logic [W-1:0] eb = ref_bus(en, dat);
    int cnt = ref_count(en);
    logic [W-1:0] ab  = regd ? r_bus   : c_bus;
    logic         am  = regd ? r_multi : c_multi;
    logic         an  = regd ? r_none  : c_none;
    logic         av  = regd ? r_valid : c_valid;
    logic [IW-1:0] ai = regd ? r_idx   : c_idx;
    logic         aq  = regd ? r_irq   : c_irq;
    string sfx = regd ? " R8 reg" : " R8 comb";
    if (cnt == 0)      chk(ab == eb, {"R1 bus", sfx}, 32'(ab), 32'(eb));
    else if (cnt == 1) chk(ab == eb, {"R2 bus", sfx}, 32'(ab), 32'(eb));
    else               chk(ab == eb, {"R3 bus", sfx}, 32'(ab), 32'(eb));
    chk(am == (cnt > 1),  {"R4 multi", sfx}, 32'(am), 32'(cnt > 1));
    chk(an == (cnt == 0), {"R5 none",  sfx}, 32'(an), 32'(cnt == 0));
    chk(av == (cnt == 1), {"R6 valid", sfx}, 32'(av), 32'(cnt == 1));
    if (cnt == 1) chk(int'(ai) == ref_first(en), {"R6 idx", sfx}, 32'(ai), 32'(ref_first(en)));
    chk(aq == (pull == '0), {"R7 irq", sfx}, 32'(aq), 32'(pull == '0));
  endtask

  task automatic apply(input logic [N-1:0] en, input logic [N*W-1:0] dat, input logic [NI-1:0] pull);
    @(negedge clk);
    drv_en = en; drv_data = dat; irq_pull = pull;
    #1 check_set(1'b0, en, dat, pull);
    @(posedge clk);
    #1 check_set(1'b1, en, dat, pull);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] en;
    logic [N*W-1:0] dat;
    rst_n = 1'b0;
    drv_en = '1; drv_data = 32'h0F0F_3C5A; irq_pull = '1;
    // R9: reset holds outputs while inputs are busy
    repeat (3) @(posedge clk);
    #1;
    chk(r_bus == '1,    "R9 reset bus",   32'(r_bus), 32'hFF);
    chk(r_none == 1'b1, "R9 reset none",  32'(r_none), 1);
    chk(r_multi == 1'b0,"R9 reset multi", 32'(r_multi), 0);
    chk(r_valid == 1'b0,"R9 reset valid", 32'(r_valid), 0);
    chk(r_idx == '0,    "R9 reset idx",   32'(r_idx), 0);
    chk(r_irq == 1'b1,  "R9 reset irq",   32'(r_irq), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // Directed corner cases
    apply('0, 32'h0000_0000, '0);                 // R1 idle with zero data
    for (int k = 0; k < N; k++)                   // R2 each lone driver
      apply(N'(1) << k, 32'hA5C3_1E78 ^ (32'h1111_1111 * k), NI'(1) << (k % NI));
    apply('1, 32'hFF00_F0AA, '1);                 // R3 all drivers, conflicting
    apply(4'b0101, 32'h00FF_FF0F, 3'b010);        // R3 disabled zeros ignored
    apply(4'b1010, 32'hF0F0_0F0F, '0);

    void'($urandom(32'd20240611));
    for (int it = 0; it < 400; it++) begin
      dat = $urandom;
      case ($urandom % 4)
        0: en = '0;
        1: en = N'(1) << ($urandom % N);
        2: en = N'($urandom);
        default: en = '1;
      endcase
      apply(en, dat, NI'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule